// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Source

This block sits beside a processor core and collects its interrupt requests. It watches twelve maskable request lines, which carry the interrupt numbers 4 through 15, and one non-maskable line. A rising edge on any line sets that line's flag. Each maskable flag is gated by its own enable bit and by one global enable bit. The non-maskable flag is gated only by an armed bit. The armed bit drops while a non-maskable service routine is running. The controller picks the winning interrupt and offers its number and vector address to the core. When the core reports that it has taken the interrupt, the controller updates the flag, enable and return state.

Software reaches every register through a single-cycle read/write port. The vector-pointer register combines a writable table base with the number of the highest-priority pending enabled interrupt. This lets a routine poll for work without using the request output. A maskable routine can be nested by setting the global enable again. A non-maskable routine cannot be interrupted at all.

Top module: `pirq_ctrl`

## Requirements
- R1: A rising edge on irq_in[i] sets the flag of interrupt i+4 on the next clock. A line that stays high does not set the flag again after software clears it.
- R2: Writing the clear register (address 2) clears each maskable flag whose bit is 1 and leaves the other flags as they were. Bit 1 of the clear register has no effect on the non-maskable flag.
- R3: Writing the set register (address 3) sets each maskable flag whose bit is 1. A rising edge that arrives in the same cycle as a clear write to the same flag leaves the flag set.
- R4: Vector register (address 4): bits 31:10 hold a writable table base, bits 4:0 read as zero, and bits 9:5 hold the winning number. The winning number is 1 when the non-maskable flag is set. Otherwise it is the lowest number whose flag and enable are both set, or 0 when there is none. The global enable does not affect this field.
- R5: irq_req is high when the armed bit is set and either the non-maskable flag is set or the global enable is set with some enabled maskable flag pending. irq_num gives the winning number while irq_req is high and is 0 otherwise. irq_vector is the base with irq_num placed at bits 9:5.
- R6: Taking a maskable interrupt (take_en while irq_req is high) clears its flag, stores take_pc in the maskable return pointer (address 6), copies the global enable into the saved-enable bit, and clears the global enable.
- R7: Taking the non-maskable interrupt clears its flag, stores take_pc in the non-maskable return pointer (address 7), copies the global enable into the NMI saved-enable bit, and clears the armed bit. While the armed bit is clear, irq_req stays low even when the global enable is set and flags are pending.
- R8: While a maskable routine runs with the global enable clear, a non-maskable edge still raises irq_req with irq_num equal to 1.
- R9: ret_mask loads the global enable from the saved-enable bit. ret_nmi sets the armed bit and loads the global enable from the NMI saved-enable bit.
- R10: take_en while irq_req is low changes no flag and no return pointer.
- R11: When software sets the global enable inside a maskable routine, a pending enabled maskable interrupt raises irq_req again, which allows nesting.
- R12: Register map:
  - 0: flags (bit n for interrupt n, bit 1 for the non-maskable flag).
  - 1: enables (bits 15:4; bit 1 always reads 1).
  - 2: clear (reads 0).
  - 3: set (reads 0).
  - 4: vector register.
  - 5: control (bit 0 global enable, bit 1 saved enable, both writable; bit 2 NMI saved enable and bit 3 armed, both read-only).
  - 6 and 7: return pointers.
  - After reset the armed bit is 1 and every other register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 12 | Maskable request lines; bit i is interrupt i+4 |
| nmi_in | input | 1 | Non-maskable request line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| take_en | input | 1 | Core has taken the offered interrupt |
| take_pc | input | 32 | Return address to save on take |
| ret_mask | input | 1 | Return from a maskable routine |
| ret_nmi | input | 1 | Return from the non-maskable routine |
| irq_req | output | 1 | An interrupt is offered to the core |
| irq_num | output | 5 | Number of the offered interrupt |
| irq_vector | output | 32 | Vector address of the offered interrupt |

## Verification
The bench sweeps every pair of maskable flags against all-enabled and single-enabled masks. A priority encoder that favours high numbers, or that ignores the enables, would read back the wrong number in the vector field. It also lands a rising edge in the same cycle as a clear write to that flag; a design that lets the clear win would lose the request. It drives a second non-maskable edge, a set global enable and a stray take strobe while the non-maskable routine runs. A design that fails to disarm would reissue a request or overwrite a return pointer. Finally it checks that each return strobe restores the global enable from its own saved copy, so a design that swapped or dropped those copies would leave nesting wrongly enabled or disabled.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int NUM_W    = 5;
  localparam int VEC_LSB  = 5;
  localparam int BASE_LSB = VEC_LSB + NUM_W;
  localparam int NMI_NUM  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG   = 3'd0,
    A_ENABLE = 3'd1,
    A_CLEAR  = 3'd2,
    A_SET    = 3'd3,
    A_VECTOR = 3'd4,
    A_CTRL   = 3'd5,
    A_RPTR   = 3'd6,
    A_NRPTR  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pirq_flags.sv
// Edge capture and flag storage for the maskable lines and the NMI line.
module pirq_flags #(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 nmi_in,
  input  logic                 clr_we,
  input  logic                 set_we,
  input  logic [NUM_LINES-1:0] wbits,
  input  logic [NUM_LINES-1:0] take_hit,
  input  logic                 take_nmi,
  output logic [NUM_LINES-1:0] mflag,
  output logic                 nmi_flag
);
  logic [NUM_LINES-1:0] line_d, rise, clr_v, set_v, mflag_nxt;
  logic                 nmi_d, nmi_nxt;

  always_comb begin
    rise      = line_in & ~line_d;
    clr_v     = clr_we ? wbits : '0;
    set_v     = set_we ? wbits : '0;
    // new edges and set writes override any clearing source
    mflag_nxt = (mflag & ~clr_v & ~take_hit) | rise | set_v;
    nmi_nxt   = (nmi_flag & ~take_nmi) | (nmi_in & ~nmi_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d   <= '0;
      nmi_d    <= 1'b0;
      mflag    <= '0;
      nmi_flag <= 1'b0;
    end else begin
      line_d   <= line_in;
      nmi_d    <= nmi_in;
      mflag    <= mflag_nxt;
      nmi_flag <= nmi_nxt;
    end
  end
endmodule

// File: rtl/pirq_select.sv
// Lowest-number-wins selection over the enabled maskable flags.
module pirq_select
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter int FIRST     = 4
) (
  input  logic [NUM_LINES-1:0] mflag,
  input  logic [NUM_LINES-1:0] enable,
  output logic                 m_any,
  output logic [NUM_LINES-1:0] m_hit,
  output logic [NUM_W-1:0]     m_num
);
  logic [NUM_LINES-1:0] pend;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pend
    assign pend[g] = mflag[g] & enable[g];
  end

  always_comb begin
    m_any = 1'b0;
    m_hit = '0;
    m_num = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        m_any    = 1'b1;
        m_hit    = '0;
        m_hit[i] = 1'b1;
        m_num    = NUM_W'(FIRST + i);
      end
    end
  end
endmodule

// File: rtl/pirq_seq.sv
// Entry/return state: global enable, saved copies, NMI arming, return pointers.
module pirq_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_m,
  input  logic              take_n,
  input  logic [DATA_W-1:0] take_pc,
  input  logic              ret_mask,
  input  logic              ret_nmi,
  input  logic              ctrl_we,
  input  logic              ctrl_gen_w,
  input  logic              ctrl_pgen_w,
  input  logic              rptr_we,
  input  logic              nrptr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              gen,
  output logic              pgen,
  output logic              npgen,
  output logic              armed,
  output logic [DATA_W-1:0] rptr,
  output logic [DATA_W-1:0] nrptr
);
  logic              gen_n, pgen_n, npgen_n, armed_n;
  logic [DATA_W-1:0] rptr_n, nrptr_n;

  // precedence: take over return over software write
  always_comb begin
    gen_n   = gen;
    pgen_n  = pgen;
    npgen_n = npgen;
    armed_n = armed;
    rptr_n  = rptr;
    nrptr_n = nrptr;
    if (ctrl_we) begin
      gen_n  = ctrl_gen_w;
      pgen_n = ctrl_pgen_w;
    end
    if (rptr_we)  rptr_n  = wdata;
    if (nrptr_we) nrptr_n = wdata;
    if (ret_nmi) begin
      armed_n = 1'b1;
      gen_n   = npgen;
    end else if (ret_mask) begin
      gen_n = pgen;
    end
    if (take_m) begin
      gen_n  = 1'b0;
      pgen_n = gen;
      rptr_n = take_pc;
    end
    if (take_n) begin
      gen_n   = 1'b0;
      npgen_n = gen;
      armed_n = 1'b0;
      nrptr_n = take_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen   <= 1'b0;
      pgen  <= 1'b0;
      npgen <= 1'b0;
      armed <= 1'b1;
      rptr  <= '0;
      nrptr <= '0;
    end else begin
      gen   <= gen_n;
      pgen  <= pgen_n;
      npgen <= npgen_n;
      armed <= armed_n;
      rptr  <= rptr_n;
      nrptr <= nrptr_n;
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter int FIRST     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 take_en,
  input  logic [DATA_W-1:0]    take_pc,
  input  logic                 ret_mask,
  input  logic                 ret_nmi,
  output logic                 irq_req,
  output logic [NUM_W-1:0]     irq_num,
  output logic [DATA_W-1:0]    irq_vector
);
  localparam int LAST   = FIRST + NUM_LINES - 1;
  localparam int BASE_W = DATA_W - BASE_LSB;

  reg_addr_e            addr;
  logic                 we_en, we_clr, we_set, we_vec, we_ctrl, we_rp, we_nrp;
  logic [NUM_LINES-1:0] wbits, en_q, en_n, mflag, m_hit, take_hit;
  logic [BASE_W-1:0]    base_q, base_n;
  logic                 nmi_flag, m_any, take_ok, take_m, take_n;
  logic                 gen, pgen, npgen, armed;
  logic [NUM_W-1:0]     m_num, hp_num;
  logic [DATA_W-1:0]    rptr, nrptr, rd_flag, rd_en;

  // ---------------- register write decode ----------------
  always_comb begin
    addr    = reg_addr_e'(reg_addr);
    wbits   = reg_wdata[LAST:FIRST];
    we_en   = reg_we && (addr == A_ENABLE);
    we_clr  = reg_we && (addr == A_CLEAR);
    we_set  = reg_we && (addr == A_SET);
    we_vec  = reg_we && (addr == A_VECTOR);
    we_ctrl = reg_we && (addr == A_CTRL);
    we_rp   = reg_we && (addr == A_RPTR);
    we_nrp  = reg_we && (addr == A_NRPTR);
    en_n    = we_en  ? wbits : en_q;
    base_n  = we_vec ? reg_wdata[DATA_W-1:BASE_LSB] : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      base_q <= '0;
    end else begin
      en_q   <= en_n;
      base_q <= base_n;
    end
  end

  // ---------------- flags, selection, sequencing ----------------
  pirq_flags #(.NUM_LINES(NUM_LINES)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (irq_in),
    .nmi_in   (nmi_in),
    .clr_we   (we_clr),
    .set_we   (we_set),
    .wbits    (wbits),
    .take_hit (take_hit),
    .take_nmi (take_n),
    .mflag    (mflag),
    .nmi_flag (nmi_flag)
  );

  pirq_select #(.NUM_LINES(NUM_LINES), .FIRST(FIRST)) u_sel (
    .mflag  (mflag),
    .enable (en_q),
    .m_any  (m_any),
    .m_hit  (m_hit),
    .m_num  (m_num)
  );

  always_comb begin
    hp_num     = nmi_flag ? NUM_W'(NMI_NUM) : m_num;
    irq_req    = armed && (nmi_flag || (gen && m_any));
    irq_num    = irq_req ? hp_num : '0;
    irq_vector = {base_q, irq_num, {VEC_LSB{1'b0}}};
    take_ok    = take_en && irq_req;
    take_n     = take_ok && nmi_flag;
    take_m     = take_ok && !nmi_flag;
    take_hit   = take_m ? m_hit : '0;
  end

  pirq_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_m      (take_m),
    .take_n      (take_n),
    .take_pc     (take_pc),
    .ret_mask    (ret_mask),
    .ret_nmi     (ret_nmi),
    .ctrl_we     (we_ctrl),
    .ctrl_gen_w  (reg_wdata[0]),
    .ctrl_pgen_w (reg_wdata[1]),
    .rptr_we     (we_rp),
    .nrptr_we    (we_nrp),
    .wdata       (reg_wdata),
    .gen         (gen),
    .pgen        (pgen),
    .npgen       (npgen),
    .armed       (armed),
    .rptr        (rptr),
    .nrptr       (nrptr)
  );

  // ---------------- read mux ----------------
  always_comb begin
    rd_flag              = '0;
    rd_flag[LAST:FIRST]  = mflag;
    rd_flag[NMI_NUM]     = nmi_flag;
    rd_en                = '0;
    rd_en[LAST:FIRST]    = en_q;
    rd_en[NMI_NUM]       = 1'b1;
    case (addr)
      A_FLAG:   reg_rdata = rd_flag;
      A_ENABLE: reg_rdata = rd_en;
      A_VECTOR: reg_rdata = {base_q, hp_num, {VEC_LSB{1'b0}}};
      A_CTRL:   reg_rdata = {{(DATA_W-4){1'b0}}, armed, npgen, pgen, gen};
      A_RPTR:   reg_rdata = rptr;
      A_NRPTR:  reg_rdata = nrptr;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
  import pirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [NUM_W-1:0] irq_num,
  input logic             take_en,
  input logic             ret_mask,
  input logic             ret_nmi,
  input logic             gen,
  input logic             pgen,
  input logic             armed,
  input logic             nmi_flag
);
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && nmi_flag |-> irq_num == NUM_W'(NMI_NUM)); // R4
  AST_MASK_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !nmi_flag |-> gen); // R5
  AST_TAKE_DROPS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    take_en && irq_req |=> !gen); // R6
  AST_NMI_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    take_en && irq_req && nmi_flag |=> !armed && !irq_req); // R7
  AST_NO_REQ_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq_req); // R7
  AST_NMI_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ret_nmi && !(take_en && irq_req && nmi_flag) |=> armed); // R9
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_mask && !ret_nmi && !take_en |=> gen == $past(pgen)); // R9
endmodule

bind pirq_ctrl pirq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .irq_num  (irq_num),
  .take_en  (take_en),
  .ret_mask (ret_mask),
  .ret_nmi  (ret_nmi),
  .gen      (gen),
  .pgen     (pgen),
  .armed    (armed),
  .nmi_flag (nmi_flag)
);

// File: tb/pirq_ctrl_test.sv
module pirq_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [11:0] irq_in;
  logic        nmi_in, reg_we, take_en, ret_mask, ret_nmi;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, take_pc, irq_vector;
  logic        irq_req;
  logic [4:0]  irq_num;
  int total, bad;
  bit done;

  localparam logic [31:0] BASE = 32'hABCD_E400;

  pirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .take_en(take_en), .take_pc(take_pc),
    .ret_mask(ret_mask), .ret_nmi(ret_nmi), .irq_req(irq_req),
    .irq_num(irq_num), .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic take(input logic [31:0] pc);
    @(negedge clk);
    take_en = 1'b1; take_pc = pc;
    @(posedge clk); #1;
    take_en = 1'b0;
  endtask

  task automatic pulse_ret(input bit nmi);
    @(negedge clk);
    if (nmi) ret_nmi = 1'b1; else ret_mask = 1'b1;
    @(posedge clk); #1;
    ret_nmi = 1'b0; ret_mask = 1'b0;
  endtask

  task automatic nmi_edge();
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int e;
    rst_n = 1'b0; irq_in = '0; nmi_in = 1'b0; reg_we = 1'b0; reg_addr = '0;
    reg_wdata = '0; take_en = 1'b0; take_pc = '0; ret_mask = 1'b0; ret_nmi = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state (R12)
    rd(3'd0, v); chk("R12 reset flags", v, 32'h0);
    rd(3'd1, v); chk("R12 reset enable", v, 32'h2);
    rd(3'd5, v); chk("R12 reset ctrl", v, 32'h8);
    rd(3'd4, v); chk("R12 reset vector", v, 32'h0);
    chk("R5 reset req", {31'b0, irq_req}, 32'h0);
    chk("R5 reset num", {27'b0, irq_num}, 32'h0);
    // R10: stray take with nothing offered
    take(32'hDEAD_0000);
    rd(3'd6, v); chk("R10 rptr untouched", v, 32'h0);

    // R1: each line latches on edge, no relatch while held
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); irq_in[i] = 1'b1;
      rd(3'd0, v); chk("R1 edge latch", v, 32'h1 << (i + 4));
      wr(3'd2, 32'h1 << (i + 4));
      settle();
      rd(3'd0, v); chk("R1 held no relatch", v, 32'h0);
      irq_in[i] = 1'b0;
    end

    // R2/R3: set and clear registers
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R3 set all", v, 32'h0000_FFF0);
    wr(3'd2, 32'h0000_00A0);
    rd(3'd0, v); chk("R2 partial clear", v, 32'h0000_FF50);
    rd(3'd2, v); chk("R12 clear reads 0", v, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 clear all", v, 32'h0);
    // R3: edge and clear of the same flag in one cycle
    wr(3'd3, 32'h0000_0100);
    @(negedge clk);
    irq_in[4] = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_0100;
    @(posedge clk); #1 reg_we = 1'b0;
    rd(3'd0, v); chk("R3 edge beats clear", v, 32'h0000_0100);
    irq_in[4] = 1'b0;
    wr(3'd2, 32'hFFFF_FFFF);

    // R4: priority sweep, GEN off
    wr(3'd4, BASE | 32'h3FF);
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        wr(3'd1, 32'h0000_FFF0);
        wr(3'd3, (32'h1 << (i + 4)) | (32'h1 << (j + 4)));
        e = ((i < j) ? i : j) + 4;
        rd(3'd4, v); chk("R4 lowest number wins", v, BASE | (32'(e) << 5));
        chk("R5 no req without gen", {31'b0, irq_req}, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'h1 << (j + 4));
        wr(3'd3, 32'h1 << (i + 4));
        e = (i == j) ? i + 4 : 0;
        rd(3'd4, v); chk("R4 enable gates field", v, BASE | (32'(e) << 5));
        wr(3'd2, 32'hFFFF_FFFF);
      end
    end

    // R5: request gating
    wr(3'd1, 32'h0000_FFF0);
    wr(3'd5, 32'h1);
    wr(3'd3, 32'h1 << 7);
    settle();
    chk("R5 req", {31'b0, irq_req}, 32'h1);
    chk("R5 num", {27'b0, irq_num}, 32'd7);
    chk("R5 vector", irq_vector, BASE | (32'd7 << 5));
    wr(3'd1, 32'h0);
    settle();
    chk("R5 enable off", {31'b0, irq_req}, 32'h0);
    chk("R5 num zero", {27'b0, irq_num}, 32'h0);
    wr(3'd1, 32'h0000_FFF0);
    wr(3'd5, 32'h0);
    settle();
    chk("R5 gen off", {31'b0, irq_req}, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);

    // R6 / R11: take and nesting
    wr(3'd5, 32'h1);
    wr(3'd3, (32'h1 << 9) | (32'h1 << 6));
    settle();
    chk("R6 offered num", {27'b0, irq_num}, 32'd6);
    take(32'h0000_1234);
    rd(3'd5, v); chk("R6 ctrl after take", v, 32'hA);
    rd(3'd0, v); chk("R6 flag cleared", v, 32'h1 << 9);
    rd(3'd6, v); chk("R6 rptr", v, 32'h0000_1234);
    chk("R6 no req", {31'b0, irq_req}, 32'h0);
    wr(3'd5, 32'h3);
    settle();
    chk("R11 nested req", {31'b0, irq_req}, 32'h1);
    chk("R11 nested num", {27'b0, irq_num}, 32'd9);
    take(32'h0000_2000);
    rd(3'd6, v); chk("R11 rptr", v, 32'h0000_2000);
    rd(3'd5, v); chk("R11 ctrl", v, 32'hA);
    pulse_ret(1'b0);
    rd(3'd5, v); chk("R9 ret_mask restores gen", v, 32'hB);

    // R7 / R8 / R9 / R10: NMI handling
    wr(3'd5, 32'h1);
    wr(3'd3, 32'h1 << 5);
    take(32'h0000_3000);
    rd(3'd5, v); chk("R6 ctrl in isr", v, 32'hA);
    nmi_edge();
    settle();
    chk("R8 nmi req", {31'b0, irq_req}, 32'h1);
    chk("R8 nmi num", {27'b0, irq_num}, 32'd1);
    chk("R8 nmi vector", irq_vector, BASE | (32'd1 << 5));
    wr(3'd2, 32'h2);
    rd(3'd0, v); chk("R2 nmi flag ignores clear", v, 32'h2);
    take(32'h0000_4000);
    rd(3'd0, v); chk("R7 nmi flag cleared", v, 32'h0);
    rd(3'd7, v); chk("R7 nrptr", v, 32'h0000_4000);
    rd(3'd5, v); chk("R7 disarmed ctrl", v, 32'h2);
    wr(3'd5, 32'h3);
    wr(3'd3, 32'h1 << 4);
    nmi_edge();
    settle();
    chk("R7 no req disarmed", {31'b0, irq_req}, 32'h0);
    rd(3'd4, v); chk("R4 field shows nmi", v, BASE | (32'd1 << 5));
    take(32'h0000_5000);
    rd(3'd6, v); chk("R10 rptr kept", v, 32'h0000_3000);
    rd(3'd7, v); chk("R10 nrptr kept", v, 32'h0000_4000);
    rd(3'd0, v); chk("R10 flags kept", v, 32'h12);
    pulse_ret(1'b1);
    rd(3'd5, v); chk("R9 ret_nmi rearm", v, 32'hA);
    chk("R9 nmi offered again", {27'b0, irq_num}, 32'd1);
    take(32'h0000_6000);
    rd(3'd5, v); chk("R7 second nmi ctrl", v, 32'h2);
    pulse_ret(1'b1);
    settle();
    chk("R9 gen stays off", {31'b0, irq_req}, 32'h0);
    pulse_ret(1'b0);
    rd(3'd5, v); chk("R9 ret_mask gen", v, 32'hB);
    chk("R9 maskable offered", {27'b0, irq_num}, 32'd4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule